// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is a per-core countdown timer. Each clock cycle a system time source may present a count of elapsed ticks (`tick_cnt`, qualified by `tick_vld`). The block scales that count down by a programmable power-of-two ratio and subtracts the result from a 32-bit current count. When the scaled ticks reach or pass the current count, the timer expires. If its table entry is unmasked, it then emits a one-cycle raise request that carries the programmed 8-bit vector, for a separate interrupt tracker to accept. Delivery is always fixed.

Software programs four registers through a simple write port and reads them back through a combinational read port: the table entry (vector, mask, mode), the initial count, the current count and the divide configuration. In periodic mode an expiry reloads the count from the initial count and keeps the surplus ticks, so the long-run rate stays exact. In one-shot mode the count stops at zero.

A control state machine with three states follows the registers. OFF holds while the initial count is zero. RUN counts down. HALT holds after a one-shot expiry. The state is re-derived after every write and every tick. A write of a non-zero initial count moves any state to RUN. A write of zero moves any state to OFF. A one-shot expiry moves RUN to HALT. A current-count write of zero in one-shot mode moves RUN to HALT. A non-zero current-count write, or switching the mode to periodic, moves HALT to RUN. A periodic expiry keeps the state in RUN.

Top module: `tick_countdown_timer`

## Requirements
- R1: After reset, the table entry reads 0x00010000 (masked, one-shot, vector 0), the initial count, current count and divide configuration read 0, and `fire` is low.
- R2: Register select codes are 0 = table entry, 1 = initial count, 2 = current count, 3 = divide configuration. The table entry holds the vector in bits 7:0, the mask in bit 16 and the mode in bit 17 (1 = periodic). The divide register keeps bits 3:0. All other bits read as 0.
- R3: Writing the initial count loads the same value into the current count.
- R4: Writing the current count replaces it directly and leaves the initial count unchanged.
- R5: While the initial count is 0 the current count does not change on ticks and no raise is issued.
- R6: The ratio code is {bit3, bit1, bit0} of the divide register. Codes 000 to 110 select shift values 1 to 7 (divide by 2 to 128), and code 111 selects shift 0 (divide by 1). Scaled ticks are `tick_cnt` shifted right by that amount.
- R7: When bit 2 of the divide register is set, ticks leave the current count unchanged and no raise is issued.
- R8: When the scaled ticks are below the current count, the current count decreases by the scaled ticks.
- R9: In one-shot mode, scaled ticks at or above the current count set it to 0. Further ticks then change nothing and raise nothing until a register write.
- R10: In periodic mode, scaled ticks at or above the current count set it to initial − ((scaled − current) mod initial).
- R11: An unmasked expiry drives `fire` high for the single cycle after the expiring tick, with `fire_vec` equal to the table vector. Outside a pulse, `fire_vec` is 0.
- R12: A masked expiry updates the count exactly as R9 and R10 require, but `fire` stays low.
- R13: A register write in the same cycle as a valid tick takes effect, and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_vld | input | 1 | Tick count valid this cycle |
| tick_cnt | input | TICK_W (8) | Elapsed system ticks this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | CNT_W (32) | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | CNT_W (32) | Combinational read data |
| fire | output | 1 | Raise request pulse |
| fire_vec | output | 8 | Vector carried with the raise |

## Verification
A write issued in one cycle becomes visible on `rd_data` in the next cycle, because the read mux is combinational over the registers the write edge updates. A tick sampled at an edge updates the current count at that same edge, and its raise appears on `fire` and `fire_vec` during the following cycle only. The bench therefore drives every stimulus one nanosecond after a rising edge and compares `fire`, `fire_vec` and all four read selects one nanosecond after the next rising edge. Each comparison is made against a bench model that is advanced once per cycle.

// File: rtl/tct_pkg.sv
package tct_pkg;
    localparam int VEC_W        = 8;
    localparam int TBL_MASK_BIT = 16;
    localparam int TBL_MODE_BIT = 17;
    localparam int DIV_CFG_W    = 4;
    localparam int DIV_BAD_BIT  = 2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        SEL_TBL  = 2'd0,
        SEL_INIT = 2'd1,
        SEL_CUR  = 2'd2,
        SEL_DIV  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } tbl_entry_t;
endpackage

// File: rtl/tct_prescale.sv
module tct_prescale
    import tct_pkg::*;
#(
    parameter int TICK_W = 8
) (
    input  logic [DIV_CFG_W-1:0] div_cfg,
    input  logic [TICK_W-1:0]    tick_cnt,
    output logic                 div_ok,
    output logic [TICK_W-1:0]    scaled
);
    localparam int N_RATIO = 8;
    localparam int SH_W    = $clog2(N_RATIO);

    logic [TICK_W-1:0] shifted [N_RATIO];
    logic [SH_W-1:0]   code;
    logic [SH_W-1:0]   shamt;

    for (genvar k = 0; k < N_RATIO; k++) begin : g_shift
        assign shifted[k] = tick_cnt >> k;
    end

    // Code 111 wraps to shift 0 (divide by one).
    assign code   = {div_cfg[3], div_cfg[1], div_cfg[0]};
    assign shamt  = code + SH_W'(1);
    assign div_ok = ~div_cfg[DIV_BAD_BIT];
    assign scaled = shifted[shamt];
endmodule

// File: rtl/tct_reload.sv
module tct_reload #(
    parameter int CNT_W  = 32,
    parameter int TICK_W = 8
) (
    input  logic [CNT_W-1:0]  init_cnt,
    input  logic [CNT_W-1:0]  cur_cnt,
    input  logic [TICK_W-1:0] scaled,
    output logic              hit,
    output logic [CNT_W-1:0]  dec_cnt,
    output logic [CNT_W-1:0]  reload_cnt
);
    localparam int PAD_W = CNT_W - TICK_W;

    logic [CNT_W-1:0]  scaled_w;
    logic [TICK_W-1:0] surplus;
    logic [CNT_W-1:0]  surplus_w;
    logic [TICK_W-1:0] divisor;
    logic [TICK_W-1:0] rem;

    assign scaled_w = {{PAD_W{1'b0}}, scaled};
    assign hit      = scaled_w >= cur_cnt;
    assign dec_cnt  = cur_cnt - scaled_w;

    // On a hit the current count is no larger than the scaled ticks,
    // so the surplus fits in the tick width.
    assign surplus   = scaled - cur_cnt[TICK_W-1:0];
    assign surplus_w = {{PAD_W{1'b0}}, surplus};

    // The modulo is needed only when the initial count is no larger than the
    // surplus, in which case it also fits in the tick width.
    assign divisor = (init_cnt[TICK_W-1:0] == '0) ? TICK_W'(1) : init_cnt[TICK_W-1:0];
    assign rem     = (init_cnt > surplus_w) ? surplus : (surplus % divisor);

    assign reload_cnt = init_cnt - {{PAD_W{1'b0}}, rem};
endmodule

// File: rtl/tct_core.sv
module tct_core
    import tct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic                 tick_vld,
    input  logic                 div_ok,
    input  logic                 hit,
    input  logic [CNT_W-1:0]     dec_cnt,
    input  logic [CNT_W-1:0]     reload_cnt,
    output logic [CNT_W-1:0]     init_q,
    output logic [CNT_W-1:0]     cur_q,
    output logic [DIV_CFG_W-1:0] div_q,
    output tbl_entry_t           tbl_q,
    output logic                 fire,
    output logic [VEC_W-1:0]     fire_vec
);
    tmr_state_e           state_q, state_d;
    logic [CNT_W-1:0]     init_d, cur_d;
    logic [DIV_CFG_W-1:0] div_d;
    tbl_entry_t           tbl_d;
    logic                 expire;

    function automatic tmr_state_e classify(input logic [CNT_W-1:0] ini,
                                            input logic [CNT_W-1:0] cur,
                                            input logic             per);
        if (ini == '0)
            return ST_OFF;
        else if (!per && cur == '0)
            return ST_HALT;
        else
            return ST_RUN;
    endfunction

    // Next-value and transition logic
    always_comb begin
        init_d = init_q;
        cur_d  = cur_q;
        div_d  = div_q;
        tbl_d  = tbl_q;
        expire = 1'b0;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_TBL: begin
                    tbl_d.vector   = wr_data[VEC_W-1:0];
                    tbl_d.masked   = wr_data[TBL_MASK_BIT];
                    tbl_d.periodic = wr_data[TBL_MODE_BIT];
                end
                SEL_INIT: begin
                    init_d = wr_data;
                    cur_d  = wr_data;
                end
                SEL_CUR: cur_d = wr_data;
                SEL_DIV: div_d = wr_data[DIV_CFG_W-1:0];
            endcase
        end else if (tick_vld && div_ok) begin
            unique case (state_q)
                ST_RUN: begin
                    if (hit) begin
                        expire = 1'b1;
                        cur_d  = tbl_q.periodic ? reload_cnt : '0;
                    end else begin
                        cur_d = dec_cnt;
                    end
                end
                ST_OFF, ST_HALT: begin
                end
                default: begin
                end
            endcase
        end
        state_d = classify(init_d, cur_d, tbl_d.periodic);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // Programmable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= '0;
            cur_q  <= '0;
            div_q  <= '0;
            tbl_q  <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
        end else begin
            init_q <= init_d;
            cur_q  <= cur_d;
            div_q  <= div_d;
            tbl_q  <= tbl_d;
        end
    end

    // Raise outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire     <= 1'b0;
            fire_vec <= '0;
        end else begin
            fire     <= expire && !tbl_q.masked;
            fire_vec <= (expire && !tbl_q.masked) ? tbl_q.vector : '0;
        end
    end

    a_r3_init_loads_cur: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == SEL_INIT |=> init_q == $past(wr_data) && cur_q == $past(wr_data));

    a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_OFF && !wr_en |=> $stable(cur_q) && !fire);

    a_r7_bad_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !div_ok && !wr_en |=> $stable(cur_q) && !fire);

    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALT && !wr_en |=> state_q == ST_HALT && cur_q == '0 && !fire);

    a_r10_reload_range: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN && tick_vld && div_ok && !wr_en && hit && tbl_q.periodic
        |=> cur_q != '0 && cur_q <= init_q);

    a_r11_fire_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !tbl_q.masked && fire_vec == tbl_q.vector);

    a_r13_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == SEL_CUR |=> cur_q == $past(wr_data) && !fire);
endmodule

// File: rtl/tick_countdown_timer.sv
module tick_countdown_timer
    import tct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_vld,
    input  logic [TICK_W-1:0] tick_cnt,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [1:0]        rd_sel,
    output logic [CNT_W-1:0]  rd_data,
    output logic              fire,
    output logic [VEC_W-1:0]  fire_vec
);
    logic [CNT_W-1:0]     init_q, cur_q, dec_cnt, reload_cnt;
    logic [DIV_CFG_W-1:0] div_q;
    tbl_entry_t           tbl_q;
    logic                 div_ok, hit;
    logic [TICK_W-1:0]    scaled;

    tct_prescale #(.TICK_W(TICK_W)) u_prescale (
        .div_cfg (div_q),
        .tick_cnt(tick_cnt),
        .div_ok  (div_ok),
        .scaled  (scaled)
    );

    tct_reload #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_reload (
        .init_cnt  (init_q),
        .cur_cnt   (cur_q),
        .scaled    (scaled),
        .hit       (hit),
        .dec_cnt   (dec_cnt),
        .reload_cnt(reload_cnt)
    );

    tct_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .tick_vld  (tick_vld),
        .div_ok    (div_ok),
        .hit       (hit),
        .dec_cnt   (dec_cnt),
        .reload_cnt(reload_cnt),
        .init_q    (init_q),
        .cur_q     (cur_q),
        .div_q     (div_q),
        .tbl_q     (tbl_q),
        .fire      (fire),
        .fire_vec  (fire_vec)
    );

    always_comb begin
        rd_data = '0;
        unique case (reg_sel_e'(rd_sel))
            SEL_TBL: begin
                rd_data[VEC_W-1:0]   = tbl_q.vector;
                rd_data[TBL_MASK_BIT] = tbl_q.masked;
                rd_data[TBL_MODE_BIT] = tbl_q.periodic;
            end
            SEL_INIT: rd_data = init_q;
            SEL_CUR:  rd_data = cur_q;
            SEL_DIV:  rd_data[DIV_CFG_W-1:0] = div_q;
        endcase
    end
endmodule

// File: tb/tick_countdown_timer_tb.sv
`timescale 1ns/100ps
module tick_countdown_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_vld = 1'b0;
    logic [7:0]  tick_cnt = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        fire;
    logic [7:0]  fire_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the programmable state
    bit [31:0] m_init, m_cur;
    bit [3:0]  m_div;
    bit [7:0]  m_vec;
    bit        m_mask, m_per;

    always #2 clk = ~clk;

    tick_countdown_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_vld(tick_vld), .tick_cnt(tick_cnt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .fire(fire), .fire_vec(fire_vec)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int unsigned shift_of(input bit [3:0] d);
        case ({d[3], d[1], d[0]})
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return 3;
            3'b011: return 4;
            3'b100: return 5;
            3'b101: return 6;
            3'b110: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic bit [31:0] model_read(input int k);
        case (k)
            0: return {14'd0, m_per, m_mask, 8'd0, m_vec};
            1: return m_init;
            2: return m_cur;
            default: return {28'd0, m_div};
        endcase
    endfunction

    task automatic read_all(input string tag);
        for (int k = 0; k < 4; k++) begin
            rd_sel = k[1:0];
            #0.1;
            chk(rd_data, model_read(k), tag);
        end
    endtask

    task automatic step(input bit w, input bit [1:0] s, input bit [31:0] d,
                        input bit tv, input bit [7:0] tc);
        string tag, ftag;
        bit ef, expired;
        bit [7:0] ev;
        longint unsigned dv, sur;
        wr_en = w; wr_sel = s; wr_data = d; tick_vld = tv; tick_cnt = tc;
        ef = 0; ev = 0; expired = 0; tag = "R2";
        if (w) begin
            case (s)
                2'd0: begin m_vec = d[7:0]; m_mask = d[16]; m_per = d[17]; tag = "R2"; end
                2'd1: begin m_init = d; m_cur = d; tag = "R3"; end
                2'd2: begin m_cur = d; tag = "R4"; end
                default: begin m_div = d[3:0]; tag = "R2"; end
            endcase
            if (tv) tag = {tag, " R13"};
        end else if (tv) begin
            if (m_init == 0) tag = "R5";
            else if (m_div[2]) tag = "R7";
            else if (!m_per && m_cur == 0) tag = "R9";
            else begin
                dv = longint'(tc) >> shift_of(m_div);
                if (dv < m_cur) begin
                    m_cur = m_cur - 32'(dv);
                    tag = "R6 R8";
                end else begin
                    expired = 1;
                    sur = dv - m_cur;
                    if (m_per) begin
                        m_cur = m_init - 32'(sur % m_init);
                        tag = "R10";
                    end else begin
                        m_cur = 0;
                        tag = "R9";
                    end
                    if (!m_mask) begin ef = 1; ev = m_vec; end
                end
            end
        end
        @(posedge clk);
        #1;
        wr_en = 0; tick_vld = 0;
        ftag = ef ? "R11" : (expired ? "R12" : tag);
        chk({31'd0, fire}, {31'd0, ef}, ftag);
        chk({24'd0, fire_vec}, {24'd0, ev}, "R11");
        read_all(tag);
    endtask

    initial begin
        bit [31:0] d;
        int r;
        void'($urandom(32'd9157));
        m_init = 0; m_cur = 0; m_div = 0; m_vec = 0; m_mask = 1; m_per = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk({31'd0, fire}, 32'd0, "R1");
        read_all("R1");

        // directed cases
        step(1, 3, 32'hB, 0, 0);            // divide by 1
        step(1, 0, 32'h0000_0042, 0, 0);    // one-shot, unmasked, vector 0x42
        step(1, 1, 32'd10, 0, 0);           // R3
        step(0, 0, 0, 1, 8'd3);             // R8: 10 -> 7
        step(0, 0, 0, 1, 8'd7);             // R9/R11: expire
        step(0, 0, 0, 1, 8'd5);             // R9: halted
        step(0, 0, 0, 1, 8'd0);
        step(1, 0, 32'h0002_0055, 0, 0);    // periodic, vector 0x55
        step(1, 1, 32'd10, 0, 0);
        step(0, 0, 0, 1, 8'd25);            // R10: surplus 15 -> count 5
        step(1, 3, 32'h0, 0, 0);            // R6 divide by 2
        step(0, 0, 0, 1, 8'd8);             // 5 - 4 = 1
        step(1, 3, 32'hA, 0, 0);            // divide by 128
        step(1, 1, 32'd100, 0, 0);
        step(0, 0, 0, 1, 8'd255);           // 100 - 1 = 99
        step(1, 3, 32'h4, 0, 0);            // R7 bad code
        step(0, 0, 0, 1, 8'd200);
        step(1, 3, 32'hB, 0, 0);
        step(1, 1, 32'd0, 0, 0);            // R5 init zero
        step(0, 0, 0, 1, 8'd50);
        step(1, 1, 32'd20, 0, 0);
        step(1, 2, 32'd3, 0, 0);            // R4
        step(0, 0, 0, 1, 8'd2);
        step(1, 0, 32'h0001_0077, 0, 0);    // masked one-shot
        step(0, 0, 0, 1, 8'd5);             // R12
        step(1, 1, 32'd30, 1, 8'd9);        // R13
        step(0, 0, 0, 1, 8'd31);            // R9 exact overshoot, masked
        step(1, 0, 32'hFFFF_FFFF, 0, 0);    // R2 unused bits read 0
        step(1, 3, 32'hFFFF_FFF0, 0, 0);
        step(1, 2, 32'd0, 0, 0);            // periodic with count 0
        step(1, 3, 32'hB, 0, 0);
        step(1, 1, 32'd7, 0, 0);
        step(0, 0, 0, 1, 8'd7);             // R10 exact hit -> reload 7

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            bit w, tv;
            bit [1:0] s;
            r = $urandom % 100;
            w = (r < 12);
            s = 2'($urandom % 4);
            case (s)
                2'd0: d = {14'd0, 1'($urandom % 2), 1'(($urandom % 10) < 3), 8'd0, 8'($urandom)};
                2'd1: d = $urandom % 48;
                2'd2: d = $urandom % 64;
                default: begin
                    d = $urandom % 16;
                    if (($urandom % 10) != 0) d[2] = 1'b0;
                end
            endcase
            tv = (($urandom % 100) < 75);
            step(w, s, d, tv, 8'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule